// File: doc/BRIEF.md
# Disk Controller Command and Status Registers

This block is the command front end of a controller that serves one attached disk drive. The host writes a command byte. The block classifies the opcode and stays busy for a fixed number of cycles. It then updates the error register and pulses an interrupt request. The drive's ready and seek-complete lines feed the status register directly. They are gated by which drive the host has selected.

Only the first drive-select position is wired. Selecting the second position finds nothing, and the status register reads zero. Two commands always run: self-diagnostics and drive-parameter setup. Recalibrate, read and seek complete as stubs, but only when a ready drive is selected at the moment of the write. Every other opcode ends in an abort, and that includes the identify command (ECh). The block moves no media data.

Top module: `disk_cmd_regs`

## Requirements
- R1: After reset the error register reads 01h, the interrupt request is low and the status busy bit (bit 7) is clear.
- R2: With drive 1 selected (`drv_sel`=0) and `drv_ready`=1, status bit 6 equals `drv_ready` and status bit 4 equals `drv_seek_done`. Bits 5, 3, 2 and 1 read 0.
- R3: When `drv_sel`=1 or `drv_ready`=0, the status register reads 00h.
- R4: A command write sets busy (status bit 7) for exactly BUSY_CYCLES cycles, starting on the cycle after the write. `irq_o` is high for exactly one cycle, the first cycle in which busy is clear. It is low at all other times.
- R5: Opcode 90h (diagnostics) completes with the error register at 01h and status bit 0 clear, whether or not a drive is present.
- R6: Opcode 91h (parameter setup) completes with the error register at 00h and status bit 0 clear, whether or not a drive is present.
- R7: Opcodes 10h–1Fh (recalibrate), 20h–23h (read) and 70h–7Fh (seek) complete with the error register at 00h when a ready drive 1 was selected at the write.
- R8: The same opcodes, written with no ready drive 1 selected, complete with the error register at 04h (abort, bit 2).
- R9: Every other opcode, including ECh (identify), completes with the error register at 04h. When the status is visible, status bit 0 (error) is then set until the next command write.
- R10: A command write while busy is ignored. The busy time and the result of the running command are unchanged, and only one interrupt pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_data | input | 8 | Command opcode |
| drv_sel | input | 1 | Drive select: 0 = drive 1, 1 = drive 2 |
| drv_ready | input | 1 | Drive at speed |
| drv_seek_done | input | 1 | Drive seek complete |
| status_o | output | 8 | Status register |
| error_o | output | 8 | Error register |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
Status bits 6 and 4 follow the drive inputs within the same cycle, so the bench checks them half a cycle after changing the inputs. The busy bit rises one cycle after the write strobe is sampled. It is checked at every falling edge during the BUSY_CYCLES window. The error register and the interrupt pulse change together on the following edge, one cycle after busy ends. The bench samples them there and checks one cycle later that the pulse has dropped. Each expected value is computed from the opcode and from the drive presence held at the write.

// File: rtl/disk_cmd_pkg.sv
package disk_cmd_pkg;

    localparam logic [7:0] OP_DIAG       = 8'h90;
    localparam logic [7:0] OP_SET_PARAMS = 8'h91;

    localparam int ST_BUSY  = 7;
    localparam int ST_READY = 6;
    localparam int ST_SEEK  = 4;
    localparam int ST_ERR   = 0;
    localparam int ER_ABORT = 2;

    localparam logic [7:0] ERR_NONE_DIAG = 8'h01;
    localparam logic [7:0] ERR_CLEAR     = 8'h00;
    localparam logic [7:0] ERR_ABORTED   = 8'h04;

    typedef enum logic [1:0] {
        RES_DIAG  = 2'd0,
        RES_OK    = 2'd1,
        RES_ABORT = 2'd2
    } cmd_res_e;

endpackage

// File: rtl/disk_cmd_decode.sv
module disk_cmd_decode
    import disk_cmd_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       present,
    output cmd_res_e   result
);
    logic is_stub;

    always_comb begin
        is_stub = (opcode[7:4] == 4'h1)
               || (opcode[7:2] == 6'b0010_00)
               || (opcode[7:4] == 4'h7);
        if (opcode == OP_DIAG) begin
            result = RES_DIAG;
        end else if (opcode == OP_SET_PARAMS) begin
            result = RES_OK;
        end else if (is_stub && present) begin
            result = RES_OK;
        end else begin
            result = RES_ABORT;
        end
    end
endmodule

// File: rtl/disk_cmd_seq.sv
module disk_cmd_seq
    import disk_cmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  cmd_res_e   res_in,
    output logic       busy_o,
    output logic       err_flag_o,
    output logic [7:0] error_o,
    output logic       irq_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        cmd_res_e      res;
        logic [7:0]    err;
        logic          err_flag;
        logic          irq;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (!s_q.busy) begin
            if (cmd_wr) begin
                s_d.busy     = 1'b1;
                s_d.cnt      = CNT_LOAD;
                s_d.res      = res_in;
                s_d.err_flag = 1'b0;
            end
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else begin
            s_d.busy = 1'b0;
            s_d.irq  = 1'b1;
            unique case (s_q.res)
                RES_DIAG:  s_d.err = ERR_NONE_DIAG;
                RES_OK:    s_d.err = ERR_CLEAR;
                default:   s_d.err = ERR_ABORTED;
            endcase
            s_d.err_flag = (s_q.res == RES_ABORT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.busy     <= 1'b0;
            s_q.cnt      <= '0;
            s_q.res      <= RES_DIAG;
            s_q.err      <= ERR_NONE_DIAG;
            s_q.err_flag <= 1'b0;
            s_q.irq      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = s_q.busy;
    assign err_flag_o = s_q.err_flag;
    assign error_o    = s_q.err;
    assign irq_o      = s_q.irq;

    // R4: interrupt only on the cycle busy has just dropped
    p_irq_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(busy_o) && !busy_o));
    // R4: interrupt lasts a single cycle
    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R4 / R10: busy starts only from a write seen while idle
    p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(cmd_wr) && !$past(busy_o)));
    // R9: an abort result raises the error flag
    p_abort_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && error_o == ERR_ABORTED) |-> err_flag_o);
endmodule

// File: rtl/disk_cmd_regs.sv
module disk_cmd_regs
    import disk_cmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_data,
    input  logic       drv_sel,
    input  logic       drv_ready,
    input  logic       drv_seek_done,
    output logic [7:0] status_o,
    output logic [7:0] error_o,
    output logic       irq_o
);
    logic     present;
    cmd_res_e res;
    logic     busy;
    logic     err_flag;

    assign present = !drv_sel && drv_ready;

    disk_cmd_decode u_decode (
        .opcode  (cmd_data),
        .present (present),
        .result  (res)
    );

    disk_cmd_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .res_in     (res),
        .busy_o     (busy),
        .err_flag_o (err_flag),
        .error_o    (error_o),
        .irq_o      (irq_o)
    );

    always_comb begin
        status_o = 8'h00;
        if (present) begin
            status_o[ST_BUSY]  = busy;
            status_o[ST_READY] = 1'b1;
            status_o[ST_SEEK]  = drv_seek_done;
            status_o[ST_ERR]   = err_flag;
        end
    end

    // R3: second drive position never shows a drive
    p_drive2_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drv_sel |-> (status_o == 8'h00));
    // R2: ready and seek-complete visible for selected drive 1
    p_ready_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_sel && drv_ready) |-> (status_o[ST_READY] && status_o[ST_SEEK] == drv_seek_done));
endmodule

// File: tb/disk_cmd_regs_tb.sv
module disk_cmd_regs_tb;
    localparam int B = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       drv_sel = 1'b0;
    logic       drv_ready = 1'b0;
    logic       drv_seek_done = 1'b0;
    logic [7:0] status_o, error_o;
    logic       irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    disk_cmd_regs #(.BUSY_CYCLES(B)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .drv_sel(drv_sel), .drv_ready(drv_ready), .drv_seek_done(drv_seek_done),
        .status_o(status_o), .error_o(error_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_err(input logic [7:0] op, input logic pres);
        logic stub;
        stub = (op[7:4] == 4'h1) || (op >= 8'h20 && op <= 8'h23) || (op[7:4] == 4'h7);
        if (op == 8'h90) return 8'h01;
        if (op == 8'h91) return 8'h00;
        if (stub && pres) return 8'h00;
        return 8'h04;
    endfunction

    function automatic logic [7:0] exp_stat(input logic bsy, input logic eflag);
        if (drv_sel || !drv_ready) return 8'h00;
        return {bsy, 1'b1, 1'b0, drv_seek_done, 3'b000, eflag};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [7:0] op, input string req);
        logic [7:0] e;
        e = exp_err(op, !drv_sel && drv_ready);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_data = op;
        @(negedge clk);
        cmd_wr = 1'b0;
        for (int k = 0; k < B; k++) begin
            chk("R4 irq low while busy", {7'd0, irq_o}, 8'h00);
            chk("R4 busy status", status_o, exp_stat(1'b1, 1'b0));
            @(negedge clk);
        end
        chk("R4 irq pulse", {7'd0, irq_o}, 8'h01);
        chk("R4 busy cleared", status_o, exp_stat(1'b0, e == 8'h04));
        chk(req, error_o, e);
        @(negedge clk);
        chk("R4 irq one cycle", {7'd0, irq_o}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 error after reset", error_o, 8'h01);
        chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);
        rst_n = 1'b1;
        drv_ready = 1'b1; drv_seek_done = 1'b1;
        @(negedge clk);
        chk("R1 busy clear", {7'd0, status_o[7]}, 8'h00);
        // R2 status follows drive inputs
        chk("R2 ready and seek", status_o, 8'h50);
        drv_seek_done = 1'b0; #1;
        chk("R2 seek low", status_o, 8'h40);
        // R3 drive 2 and not ready
        drv_sel = 1'b1; drv_seek_done = 1'b1; #1;
        chk("R3 drive 2", status_o, 8'h00);
        drv_sel = 1'b0; drv_ready = 1'b0; #1;
        chk("R3 not ready", status_o, 8'h00);
        // R5 / R6 without a drive
        run_cmd(8'h90, "R5 diag no drive");
        run_cmd(8'h91, "R6 params no drive");
        // R8 stubs without drive
        run_cmd(8'h10, "R8 recal no drive");
        drv_sel = 1'b1; drv_ready = 1'b1;
        run_cmd(8'h20, "R8 read on drive 2");
        drv_sel = 1'b0;
        // R7 stubs with drive
        run_cmd(8'h1F, "R7 recal");
        run_cmd(8'h23, "R7 read");
        run_cmd(8'h70, "R7 seek");
        // R9 identify and others, error bit visible
        run_cmd(8'hEC, "R9 identify aborts");
        run_cmd(8'h24, "R9 opcode 24h aborts");
        run_cmd(8'h90, "R5 diag with drive");
        run_cmd(8'h91, "R6 params with drive");
        // R10 write while busy ignored
        @(negedge clk);
        cmd_wr = 1'b1; cmd_data = 8'h91;
        @(negedge clk);
        cmd_data = 8'hEC;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R10 still busy", status_o, 8'hD0);
        @(negedge clk);
        chk("R10 busy length", status_o, 8'hD0);
        @(negedge clk);
        chk("R10 result kept", error_o, 8'h00);
        chk("R10 irq", {7'd0, irq_o}, 8'h01);
        @(negedge clk);
        repeat (B + 2) begin
            chk("R10 no second irq", {7'd0, irq_o}, 8'h00);
            @(negedge clk);
        end
        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [7:0] op;
            drv_sel = ($urandom % 4) == 0;
            drv_ready = ($urandom % 4) != 0;
            drv_seek_done = $urandom % 2;
            case ($urandom % 6)
                0: op = 8'h90;
                1: op = 8'h91;
                2: op = 8'h10 | 8'($urandom % 16);
                3: op = 8'h20 | 8'($urandom % 4);
                4: op = 8'h70 | 8'($urandom % 16);
                default: op = 8'($urandom);
            endcase
            run_cmd(op, "R7 R8 R9 random command");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule